// File: doc/BRIEF.md
# Private Interrupt Priority Arbiter

This block tracks the pending and active state of a core's private interrupts and chooses, every cycle, which interrupt should be presented to the core. The register block supplies the per-interrupt enable, priority and group. The global controller supplies one enable bit per group. The arbiter picks the eligible interrupt with the numerically lowest priority, breaking ties by lower ID. It also weighs one external message-based candidate against the private winner. The chosen ID, priority and group are registered, so they appear one clock after the state or configuration that produced them.

The block also owns the pending and active bits. Peripherals set pending directly, and a software-generated interrupt port sets pending after group and access filtering. The core activates and deactivates interrupts through command ports. A query port reports the state of any one interrupt. A separate output tells the distribution logic, for each group, whether this core may take part in 1-of-N selection.

Top module: `prv_irq_arbiter`

## Requirements
- R1: An interrupt is a candidate only when it is pending, enabled and not active, and its group is enabled. Group codes are 0 = group 0, 1 = secure group 1 and 2 = non-secure group 1; `grp_en[c]` enables code c. Code 3 is never a candidate.
- R2: The candidate with the lowest priority value wins, and equal priorities go to the lower ID. A priority of 0xFF is never selected.
- R3: With no winner, `hp_valid` is 0, `hp_prio` is 0xFF and `hp_id` and `hp_grp` are 0. `hp_valid` is 1 whenever `hp_prio` is not 0xFF.
- R4: The external candidate, present when `ext_vld` is set, always belongs to group code 2 and competes only while `grp_en[2]` is set. Its priority is `{ext_prio, 2'b00}` and its ID is `ext_id`, which is at least 8192. On a priority tie it loses to any private interrupt.
- R5: The outputs `hp_*` register the selection made from the pending and active state and the inputs present at the previous clock edge.
- R6: An activate command clears the pending bit and sets the active bit of `act_id`. It overrides a set of the same pending bit in the same cycle. A deactivate command clears the active bit of `deact_id` and wins over an activate of the same ID in the same cycle.
- R7: `q_state` for `q_id` is 0 (inactive), 1 (pending), 2 (active) or 3 (active and pending). It reflects the state immediately, with no register delay.
- R8: `elig[c]` is 1 only when `low_power` is 0, `grp_en[c]` is 1 and `dpg[c]` is 0. The output is combinational.
- R9: A software-generated request asking for group code 1 against a target configured as group code 0 is treated as group code 0. A group-0 request to a target that is not group 0 is dropped.
- R10: With `sec_dis` at 0, a request with `sgi_ns` set is accepted only if the target's two-bit access field `sgi_acc[2*id+1:2*id]` is at least 1 for a group-0 target, or at least 2 for a group-code-1 target. With `sec_dis` at 1 this filter is bypassed.
- R11: Synchronous active-high reset clears all pending and active bits and forces the idle result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_pend | input | 32 | Per-interrupt pending set pulse |
| irq_en | input | 32 | Per-interrupt enable |
| irq_prio | input | 256 | 8-bit priority per interrupt, interrupt i at bits [8i+7:8i] |
| irq_grp | input | 64 | 2-bit group code per interrupt, interrupt i at bits [2i+1:2i] |
| grp_en | input | 3 | Group enables indexed by group code |
| sec_dis | input | 1 | Single security state: bypasses the access filter |
| sgi_req | input | 1 | Software-generated interrupt request strobe |
| sgi_id | input | 4 | Target ID of the request |
| sgi_grp | input | 2 | Requested group code |
| sgi_ns | input | 1 | Request comes from the non-secure side |
| sgi_acc | input | 32 | 2-bit access field per software-generated interrupt |
| act_req | input | 1 | Activate command |
| act_id | input | 5 | ID to activate |
| deact_req | input | 1 | Deactivate command |
| deact_id | input | 5 | ID to deactivate |
| ext_vld | input | 1 | External candidate present |
| ext_id | input | 14 | External candidate ID |
| ext_prio | input | 6 | External candidate stored priority field |
| q_id | input | 5 | State query ID |
| q_state | output | 2 | State of `q_id` |
| low_power | input | 1 | Core is in a low-power state |
| dpg | input | 3 | Per-group 1-of-N disable bits |
| elig | output | 3 | Per-group 1-of-N eligibility |
| hp_valid | output | 1 | A winner is presented |
| hp_id | output | 14 | Winning ID |
| hp_prio | output | 8 | Winning priority |
| hp_grp | output | 2 | Winning group code |

## Verification
The bench targets priority ties between two private interrupts and between a private interrupt and the external candidate. A design that broke ties the wrong way would present the higher ID. It toggles group enables and per-interrupt enables while interrupts are pending; a missing gate would show up as a non-idle result when idle is expected. It issues activate, deactivate and set in the same cycle, which exposes a wrong override order as a mismatched query state. It also sends software requests through every group remap and access-field threshold: an off-by-one threshold, or a filter that ignores `sec_dis`, leaves a pending bit that should be clear or clears one that should be set.

// File: rtl/prv_irq_pkg.sv
package prv_irq_pkg;

    localparam int PRIO_W     = 8;
    localparam int EXT_PRIO_W = 6;
    localparam int EXT_SHIFT  = PRIO_W - EXT_PRIO_W;
    localparam int ID_W       = 14;
    localparam int NUM_GRP    = 3;
    localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;

    typedef enum logic [1:0] {
        GRP_G0   = 2'd0,
        GRP_G1S  = 2'd1,
        GRP_G1NS = 2'd2
    } grp_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PEND    = 2'd1,
        ST_ACT     = 2'd2,
        ST_ACTPEND = 2'd3
    } qstate_e;

    typedef struct packed {
        logic              vld;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
        logic [1:0]        grp;
    } win_t;

    // Group remap, group mismatch drop and non-secure access filter
    function automatic logic sgi_accept(logic [1:0] tgt, logic [1:0] req,
                                        logic ns, logic sec_dis,
                                        logic [1:0] acc);
        logic [1:0] eff;
        logic       ok;
        eff = (tgt == GRP_G0 && req == GRP_G1S) ? 2'(GRP_G0) : req;
        ok  = 1'b1;
        if (eff == GRP_G0 && tgt != GRP_G0) ok = 1'b0;
        if (ns && !sec_dis) begin
            if (tgt == GRP_G0  && acc < 2'd1) ok = 1'b0;
            if (tgt == GRP_G1S && acc < 2'd2) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/prv_irq_state.sv
module prv_irq_state
    import prv_irq_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int NUM_SGI = 16,
    localparam int IDX_W  = $clog2(NUM_IRQ),
    localparam int SGI_W  = $clog2(NUM_SGI)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_IRQ-1:0]   set_pend,
    input  logic [2*NUM_IRQ-1:0] irq_grp,
    input  logic                 sec_dis,
    input  logic                 sgi_req,
    input  logic [SGI_W-1:0]     sgi_id,
    input  logic [1:0]           sgi_grp,
    input  logic                 sgi_ns,
    input  logic [2*NUM_SGI-1:0] sgi_acc,
    input  logic                 act_req,
    input  logic [IDX_W-1:0]     act_id,
    input  logic                 deact_req,
    input  logic [IDX_W-1:0]     deact_id,
    output logic [NUM_IRQ-1:0]   pend,
    output logic [NUM_IRQ-1:0]   act
);

    logic [NUM_IRQ-1:0] sgi_set, act_oh, deact_oh;
    logic [1:0]         sgi_tgt, sgi_af;

    assign sgi_tgt  = irq_grp[{sgi_id, 1'b0} +: 2];
    assign sgi_af   = sgi_acc[{sgi_id, 1'b0} +: 2];
    assign act_oh   = act_req   ? (NUM_IRQ'(1) << act_id)   : '0;
    assign deact_oh = deact_req ? (NUM_IRQ'(1) << deact_id) : '0;

    always_comb begin
        sgi_set = '0;
        if (sgi_req && sgi_accept(sgi_tgt, sgi_grp, sgi_ns, sec_dis, sgi_af))
            sgi_set[sgi_id] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            act  <= '0;
        end else begin
            pend <= (pend | set_pend | sgi_set) & ~act_oh;
            act  <= (act | act_oh) & ~deact_oh;
        end
    end

    // R6
    act_chk: assert property (@(posedge clk) disable iff (rst)
        act_req && !(deact_req && deact_id == act_id)
        |=> act[$past(act_id)] && !pend[$past(act_id)]);

    // R6
    deact_chk: assert property (@(posedge clk) disable iff (rst)
        deact_req |=> !act[$past(deact_id)]);

endmodule

// File: rtl/prv_irq_pick.sv
module prv_irq_pick
    import prv_irq_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic [NUM_IRQ-1:0]        pend,
    input  logic [NUM_IRQ-1:0]        act,
    input  logic [NUM_IRQ-1:0]        irq_en,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [2*NUM_IRQ-1:0]      irq_grp,
    input  logic [NUM_GRP-1:0]        grp_en,
    input  logic                      ext_vld,
    input  logic [ID_W-1:0]           ext_id,
    input  logic [EXT_PRIO_W-1:0]     ext_prio,
    output win_t                      win
);

    logic [NUM_IRQ-1:0] cand;
    logic [3:0]         grp_ok;
    logic [PRIO_W-1:0]  ext_p;

    assign grp_ok = {1'b0, grp_en};
    assign ext_p  = {ext_prio, EXT_SHIFT'(0)};

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cand
        logic [1:0] gc;
        assign gc      = irq_grp[2*i +: 2];
        assign cand[i] = pend[i] & irq_en[i] & ~act[i] & grp_ok[gc];
    end

    // Strict less-than in ascending ID order: lowest value, then lowest ID
    always_comb begin
        win = '{vld: 1'b0, id: '0, prio: PRIO_IDLE, grp: 2'(GRP_G0)};
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (cand[i] && irq_prio[i*PRIO_W +: PRIO_W] < win.prio) begin
                win.vld  = 1'b1;
                win.id   = ID_W'(i);
                win.prio = irq_prio[i*PRIO_W +: PRIO_W];
                win.grp  = irq_grp[2*i +: 2];
            end
        end
        if (ext_vld && grp_en[GRP_G1NS] && ext_p < win.prio) begin
            win.vld  = 1'b1;
            win.id   = ext_id;
            win.prio = ext_p;
            win.grp  = 2'(GRP_G1NS);
        end
    end

endmodule

// File: rtl/prv_irq_arbiter.sv
module prv_irq_arbiter
    import prv_irq_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int NUM_SGI = 16,
    localparam int IDX_W  = $clog2(NUM_IRQ),
    localparam int SGI_W  = $clog2(NUM_SGI)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_IRQ-1:0]        set_pend,
    input  logic [NUM_IRQ-1:0]        irq_en,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [2*NUM_IRQ-1:0]      irq_grp,
    input  logic [NUM_GRP-1:0]        grp_en,
    input  logic                      sec_dis,
    input  logic                      sgi_req,
    input  logic [SGI_W-1:0]          sgi_id,
    input  logic [1:0]                sgi_grp,
    input  logic                      sgi_ns,
    input  logic [2*NUM_SGI-1:0]      sgi_acc,
    input  logic                      act_req,
    input  logic [IDX_W-1:0]          act_id,
    input  logic                      deact_req,
    input  logic [IDX_W-1:0]          deact_id,
    input  logic                      ext_vld,
    input  logic [ID_W-1:0]           ext_id,
    input  logic [EXT_PRIO_W-1:0]     ext_prio,
    input  logic [IDX_W-1:0]          q_id,
    output logic [1:0]                q_state,
    input  logic                      low_power,
    input  logic [NUM_GRP-1:0]        dpg,
    output logic [NUM_GRP-1:0]        elig,
    output logic                      hp_valid,
    output logic [ID_W-1:0]           hp_id,
    output logic [PRIO_W-1:0]         hp_prio,
    output logic [1:0]                hp_grp
);

    logic [NUM_IRQ-1:0] pend, act;
    win_t               win;

    prv_irq_state #(.NUM_IRQ(NUM_IRQ), .NUM_SGI(NUM_SGI)) u_state (
        .clk(clk), .rst(rst), .set_pend(set_pend), .irq_grp(irq_grp),
        .sec_dis(sec_dis), .sgi_req(sgi_req), .sgi_id(sgi_id),
        .sgi_grp(sgi_grp), .sgi_ns(sgi_ns), .sgi_acc(sgi_acc),
        .act_req(act_req), .act_id(act_id), .deact_req(deact_req),
        .deact_id(deact_id), .pend(pend), .act(act)
    );

    prv_irq_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
        .pend(pend), .act(act), .irq_en(irq_en), .irq_prio(irq_prio),
        .irq_grp(irq_grp), .grp_en(grp_en), .ext_vld(ext_vld),
        .ext_id(ext_id), .ext_prio(ext_prio), .win(win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hp_valid <= 1'b0;
            hp_id    <= '0;
            hp_prio  <= PRIO_IDLE;
            hp_grp   <= 2'(GRP_G0);
        end else begin
            hp_valid <= win.vld;
            hp_id    <= win.id;
            hp_prio  <= win.prio;
            hp_grp   <= win.grp;
        end
    end

    assign q_state = {act[q_id], pend[q_id]};

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_elig
        assign elig[g] = ~low_power & grp_en[g] & ~dpg[g];
    end

    // R3
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !hp_valid |-> hp_prio == PRIO_IDLE && hp_id == '0);

    // R3
    valid_chk: assert property (@(posedge clk) disable iff (rst)
        hp_valid |-> hp_prio != PRIO_IDLE);

    // R4
    ext_grp_chk: assert property (@(posedge clk) disable iff (rst)
        hp_valid && hp_id >= ID_W'(NUM_IRQ)
        |-> hp_grp == GRP_G1NS && hp_prio[EXT_SHIFT-1:0] == '0);

    // R8
    lowpwr_chk: assert property (@(posedge clk) disable iff (rst)
        low_power |-> elig == '0);

endmodule

// File: tb/test_prv_irq_arbiter.sv
module test_prv_irq_arbiter;

    localparam int N  = 32;
    localparam int NS = 16;

    logic          clk = 1'b0, rst = 1'b1;
    logic [N-1:0]  set_pend = '0, irq_en = '0;
    logic [N*8-1:0] irq_prio = '1;
    logic [2*N-1:0] irq_grp = '0;
    logic [2:0]    grp_en = '0, dpg = '0, elig;
    logic          sec_dis = 0, sgi_req = 0, sgi_ns = 0;
    logic [3:0]    sgi_id = '0;
    logic [1:0]    sgi_grp = '0, q_state, hp_grp;
    logic [2*NS-1:0] sgi_acc = '0;
    logic          act_req = 0, deact_req = 0, ext_vld = 0, low_power = 0;
    logic [4:0]    act_id = '0, deact_id = '0, q_id = '0;
    logic [13:0]   ext_id = 14'd8192, hp_id;
    logic [5:0]    ext_prio = '0;
    logic          hp_valid;
    logic [7:0]    hp_prio;

    always #5 clk = ~clk;

    prv_irq_arbiter i_prv_irq_arbiter (
        .clk(clk), .rst(rst), .set_pend(set_pend), .irq_en(irq_en),
        .irq_prio(irq_prio), .irq_grp(irq_grp), .grp_en(grp_en),
        .sec_dis(sec_dis), .sgi_req(sgi_req), .sgi_id(sgi_id),
        .sgi_grp(sgi_grp), .sgi_ns(sgi_ns), .sgi_acc(sgi_acc),
        .act_req(act_req), .act_id(act_id), .deact_req(deact_req),
        .deact_id(deact_id), .ext_vld(ext_vld), .ext_id(ext_id),
        .ext_prio(ext_prio), .q_id(q_id), .q_state(q_state),
        .low_power(low_power), .dpg(dpg), .elig(elig),
        .hp_valid(hp_valid), .hp_id(hp_id), .hp_prio(hp_prio), .hp_grp(hp_grp)
    );

    int    n_chk = 0, n_fail = 0;
    string tag = "R11";
    bit    mp[N], ma[N];
    int    e_vld = 0, e_id = 0, e_prio = 255, e_grp = 0;
    int    bv, bi, bp, bg, ep;

    task automatic chk(bit ok, string what, int a, int e);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, a, e);
        end
    endtask

    function automatic int grp_of(int i);
        return int'(irq_grp[2*i +: 2]);
    endfunction

    function automatic bit grp_on(int g);
        return g < 3 && grp_en[g];
    endfunction

    // R9 / R10 acceptance rule as stated
    function automatic bit sgi_ok(int id);
        int tgt, req, acc, eff;
        tgt = grp_of(id); req = int'(sgi_grp); acc = int'(sgi_acc[2*id +: 2]);
        eff = (tgt == 0 && req == 1) ? 0 : req;
        if (eff == 0 && tgt != 0) return 0;
        if (sgi_ns && !sec_dis && ((tgt == 0 && acc < 1) || (tgt == 1 && acc < 2))) return 0;
        return 1;
    endfunction

    // reference model, one step per clock
    always @(posedge clk) begin
        if (rst) begin
            foreach (mp[i]) begin mp[i] = 0; ma[i] = 0; end
            e_vld = 0; e_id = 0; e_prio = 255; e_grp = 0;
        end else begin
            bv = 0; bi = 0; bp = 255; bg = 0;
            for (int i = 0; i < N; i++) begin
                if (mp[i] && irq_en[i] && !ma[i] && grp_on(grp_of(i)) &&
                    int'(irq_prio[8*i +: 8]) < bp) begin
                    bv = 1; bi = i; bp = int'(irq_prio[8*i +: 8]); bg = grp_of(i);
                end
            end
            ep = int'(ext_prio) * 4;
            if (ext_vld && grp_en[2] && ep < bp) begin
                bv = 1; bi = int'(ext_id); bp = ep; bg = 2;
            end
            e_vld = bv; e_id = bi; e_prio = bp; e_grp = bg;
            for (int i = 0; i < N; i++) if (set_pend[i]) mp[i] = 1;
            if (sgi_req && sgi_ok(int'(sgi_id))) mp[sgi_id] = 1;
            if (act_req) begin mp[act_id] = 0; ma[act_id] = 1; end
            if (deact_req) ma[deact_id] = 0;
        end
    end

    // compared on every clock, away from the active edge
    always @(negedge clk) begin
        chk(hp_valid == e_vld[0], "hp_valid", int'(hp_valid), e_vld);
        chk(int'(hp_id) == e_id, "hp_id", int'(hp_id), e_id);
        chk(int'(hp_prio) == e_prio, "hp_prio", int'(hp_prio), e_prio);
        chk(int'(hp_grp) == e_grp, "hp_grp", int'(hp_grp), e_grp);
        chk(q_state == {ma[q_id], mp[q_id]}, "q_state", int'(q_state),
            int'({ma[q_id], mp[q_id]}));
        for (int g = 0; g < 3; g++)
            chk(elig[g] == (!low_power && grp_en[g] && !dpg[g]), "elig",
                int'(elig[g]), int'(!low_power && grp_en[g] && !dpg[g]));
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_pend(logic [N-1:0] v);
        set_pend = v; step(1); set_pend = '0;
    endtask

    task automatic sgi(int id, int g, bit ns);
        sgi_req = 1; sgi_id = 4'(id); sgi_grp = 2'(g); sgi_ns = ns;
        step(1); sgi_req = 0; sgi_ns = 0;
        q_id = 5'(id);
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        step(3);
        @(negedge clk);
        chk(hp_prio == 8'hFF && !hp_valid, "R11 reset idle", int'(hp_prio), 255);
        chk(q_state == 2'd0, "R11 reset state", int'(q_state), 0);
        rst = 0;
        tag = "R3";
        step(2);
        @(negedge clk);
        chk(hp_prio == 8'hFF && hp_id == '0, "R3 idle", int'(hp_prio), 255);

        // R2: distinct priorities
        tag = "R2";
        for (int i = 0; i < N; i++) irq_prio[8*i +: 8] = 8'(8'h80 - 2*i);
        for (int i = 0; i < N; i++) irq_grp[2*i +: 2] = 2'd2;
        irq_en = '1; grp_en = 3'b111;
        pulse_pend((N'(1) << 3) | (N'(1) << 10) | (N'(1) << 20));
        step(1); @(negedge clk);
        chk(hp_id == 14'd20 && hp_prio == 8'h58, "R2 lowest value", int'(hp_id), 20);
        // R2: tie goes to lower ID
        irq_prio[8*5 +: 8] = 8'h10; irq_prio[8*7 +: 8] = 8'h10;
        pulse_pend((N'(1) << 5) | (N'(1) << 7));
        step(1); @(negedge clk);
        chk(hp_id == 14'd5 && hp_prio == 8'h10, "R2 tie", int'(hp_id), 5);

        // R1: enables gate the candidates
        tag = "R1";
        irq_en[5] = 0; step(1); @(negedge clk);
        chk(hp_id == 14'd7, "R1 irq disable", int'(hp_id), 7);
        grp_en = 3'b011; step(1); @(negedge clk);
        chk(!hp_valid && hp_prio == 8'hFF, "R1 group disable", int'(hp_prio), 255);
        grp_en = 3'b111; irq_en[5] = 1; step(2);

        // R6 / R7: activate, re-pend, deactivate
        tag = "R6";
        act_req = 1; act_id = 5'd5; q_id = 5'd5; step(1); act_req = 0;
        @(negedge clk);
        chk(q_state == 2'd2, "R7 active", int'(q_state), 2);
        pulse_pend(N'(1) << 5); @(negedge clk);
        chk(q_state == 2'd3, "R7 active+pending", int'(q_state), 3);
        deact_req = 1; deact_id = 5'd5; step(1); deact_req = 0;
        @(negedge clk);
        chk(q_state == 2'd1, "R7 pending", int'(q_state), 1);
        act_req = 1; act_id = 5'd7; deact_req = 1; deact_id = 5'd7;
        set_pend = N'(1) << 7; q_id = 5'd7;
        step(1); act_req = 0; deact_req = 0; set_pend = '0;
        @(negedge clk);
        chk(q_state == 2'd0, "R6 same-cycle overrides", int'(q_state), 0);

        // R4: external candidate
        tag = "R4";
        ext_vld = 1; ext_id = 14'd8200; ext_prio = 6'd2;
        step(1); @(negedge clk);
        chk(hp_id == 14'd8200 && hp_prio == 8'h08 && hp_grp == 2'd2, "R4 ext wins",
            int'(hp_id), 8200);
        ext_prio = 6'd4; step(1); @(negedge clk);
        chk(hp_id == 14'd5 && hp_prio == 8'h10, "R4 tie to private", int'(hp_id), 5);
        grp_en = 3'b011; step(1); @(negedge clk);
        chk(!hp_valid, "R4 group gate", int'(hp_valid), 0);
        grp_en = 3'b111; ext_vld = 0; step(1);

        // R8: eligibility
        tag = "R8";
        low_power = 1; #1;
        chk(elig == 3'b000, "R8 low power", int'(elig), 0);
        low_power = 0; dpg = 3'b010; #1;
        chk(elig == 3'b101, "R8 dpg", int'(elig), 5);
        dpg = 3'b000; grp_en = 3'b110; #1;
        chk(elig == 3'b110, "R8 group off", int'(elig), 6);
        grp_en = 3'b111; step(1);

        // R9 / R10: software requests
        tag = "R9";
        irq_grp[2*1 +: 2] = 2'd0; irq_grp[2*2 +: 2] = 2'd1;
        irq_grp[2*4 +: 2] = 2'd0; irq_grp[2*6 +: 2] = 2'd0; irq_grp[2*8 +: 2] = 2'd1;
        sgi(1, 1, 0);
        chk(q_state == 2'd1, "R9 remap accepted", int'(q_state), 1);
        sgi(2, 0, 0);
        chk(q_state == 2'd0, "R9 group-0 drop", int'(q_state), 0);
        tag = "R10";
        sgi_acc = '0;
        sgi(4, 0, 1);
        chk(q_state == 2'd0, "R10 acc 0 drop", int'(q_state), 0);
        sgi_acc[2*4 +: 2] = 2'd1;
        sgi(4, 0, 1);
        chk(q_state == 2'd1, "R10 acc 1 accept", int'(q_state), 1);
        sgi_acc[2*8 +: 2] = 2'd1;
        sgi(8, 1, 1);
        chk(q_state == 2'd0, "R10 acc 1 drop g1s", int'(q_state), 0);
        sgi_acc[2*8 +: 2] = 2'd2;
        sgi(8, 1, 1);
        chk(q_state == 2'd1, "R10 acc 2 accept", int'(q_state), 1);
        sgi_acc = '0; sec_dis = 1;
        sgi(6, 0, 1);
        chk(q_state == 2'd1, "R10 bypass", int'(q_state), 1);

        // R5: randomised traffic against the model
        tag = "R5";
        for (int c = 0; c < 3000; c++) begin
            if (c % 64 == 0) begin
                for (int i = 0; i < N; i++) irq_prio[8*i +: 8] = 8'($urandom);
                irq_grp = {$urandom, $urandom};
            end
            set_pend  = N'($urandom & $urandom & $urandom);
            irq_en    = N'($urandom | $urandom);
            grp_en    = 3'($urandom | $urandom);
            sec_dis   = 1'($urandom);
            sgi_req   = 1'($urandom); sgi_id = 4'($urandom);
            sgi_grp   = 2'($urandom % 3); sgi_ns = 1'($urandom);
            sgi_acc   = $urandom;
            act_req   = ($urandom % 4) == 0; act_id = 5'($urandom);
            deact_req = ($urandom % 4) == 0; deact_id = 5'($urandom);
            ext_vld   = 1'($urandom); ext_prio = 6'($urandom);
            ext_id    = 14'(8192 + $urandom % 8192);
            q_id      = 5'($urandom);
            low_power = ($urandom % 8) == 0; dpg = 3'($urandom);
            step(1);
        end
        set_pend = '0; sgi_req = 0; act_req = 0; deact_req = 0;
        step(2);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule